// File: doc/BRIEF.md
# Fast Link Pulse Burst Codec

This block turns a 16-bit link code word into a timed burst of link pulses, and turns received bursts back into words. A burst has up to 33 pulse positions. The odd positions (1st, 3rd, … 33rd) are framing pulses, and all 17 of them are always present. Each even position between two framing pulses is a data slot. A pulse in a data slot is a 1 and an empty slot is a 0. Word bit 0 occupies the first slot, so the selector field, in the low five bits, goes out first. All timing is in reference-clock cycles. Three parameters set it: `FRAME_GAP` is the framing-to-framing spacing, `DATA_OFS` is the delay from a framing pulse to its data slot, and `BURST_GAP` is the spacing between burst starts.

The transmitter repeats the word it holds, one burst every `BURST_GAP` cycles, while `tx_run` is high. Words enter on a valid/ready port. `tx_ready` is low for the whole of a burst, so the word cannot change mid-burst. A word accepted between bursts is used from the next burst start. The receiver takes a one-cycle pulse strobe, already synchronised to the clock, and measures each pulse against the last framing pulse. It then reports a decoded word or a one-cycle error strobe.

The receive output is a valid/ready port with a single holding slot. A held word stays unchanged until `rx_ready` takes it. A word decoded while the slot is full is discarded. The receiver cannot stall the line, so back-pressure only drops words and never delays decoding. Parameters must satisfy `DATA_OFS+DATA_TOL < FRAME_GAP-FRAME_TOL`, `DATA_OFS > 1` and `BURST_GAP > 16*FRAME_GAP+1`.

Top module: `flp_codec`

## Requirements
- R1: Once a burst starts, `tx_pulse` marks exactly 17 framing pulses. They fall at offsets k*`FRAME_GAP` cycles (k = 0..16) from the burst's first pulse, and `tx_busy` is high for the whole span.
- R2: A data pulse appears at offset k*`FRAME_GAP`+`DATA_OFS` if and only if word bit k is 1 (k = 0..15, bit 0 in the first slot). No data pulse follows the 17th framing pulse.
- R3: While `tx_run` is high and a word has been accepted, burst starts are exactly `BURST_GAP` cycles apart. Dropping `tx_run` lets the current burst finish and starts no further burst.
- R4: `tx_ready` is low whenever `tx_busy` is high. A word accepted on `tx_valid && tx_ready` is sent unchanged in every later burst until it is replaced.
- R5: Every transmitted pulse is high for exactly one cycle.
- R6: A received burst is well formed when its 17 framing pulses are each `FRAME_GAP`±`FRAME_TOL` cycles after the previous one and any data pulse lies `DATA_OFS`±`DATA_TOL` cycles after its framing pulse. Such a burst raises `rx_valid` with `rx_word` bit k = 1 exactly when slot k held a pulse. This happens a few cycles after `FRAME_GAP+FRAME_TOL` quiet cycles follow the last framing pulse.
- R7: A burst with a framing-pulse count other than 17 gives a one-cycle `rx_err` and no `rx_valid`.
- R8: Any of the following gives `rx_err` and no `rx_valid`: a pulse outside both windows (a framing gap out of tolerance), a second pulse in one data window, or a data pulse after the 17th framing pulse.
- R9: While `rx_valid` is high and `rx_ready` is low, `rx_valid` and `rx_word` hold. A word decoded during that time is dropped.
- R10: After reset, `tx_pulse`, `tx_busy`, `rx_valid` and `rx_err` are 0 and `tx_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_run | input | 1 | Keep repeating bursts while high |
| tx_word | input | 16 | Link code word to send |
| tx_valid | input | 1 | `tx_word` is offered |
| tx_ready | output | 1 | Word can be taken (between bursts) |
| tx_pulse | output | 1 | One-cycle strobe per transmitted pulse |
| tx_busy | output | 1 | A burst is in progress |
| rx_pulse | input | 1 | One-cycle strobe per received pulse |
| rx_word | output | 16 | Decoded link code word |
| rx_valid | output | 1 | `rx_word` holds an undelivered word |
| rx_ready | input | 1 | Consumer takes `rx_word` |
| rx_err | output | 1 | One-cycle strobe for a rejected burst |

## Verification
The all-zero and all-one words are sent alongside random ones. A slot-indexing error in the transmitter would show up either as missing data pulses or as a pulse after the last framing pulse. Received bursts carry random jitter anywhere inside both tolerance windows, so a window that is one cycle too narrow turns good bursts into errors. Directed bursts cover 16 and 18 framing pulses, one short framing gap, a doubled data pulse and a trailing data pulse. An off-by-one count check or missing stray detection would let these through as valid words. A transmitter loop-back, a stop request made mid-burst and a held output under back-pressure cover three further faults: a burst cut short, an extra burst after stop, and an overwritten held word.

// File: rtl/flp_pkg.sv
package flp_pkg;
  localparam int NFRAME = 17;
  localparam int NBITS  = 16;

  typedef enum logic [1:0] {TX_IDLE, TX_BURST, TX_GAP} tx_state_e;

  // classification of one receive cycle
  typedef struct packed {
    logic start;  // first pulse of a new burst
    logic frame;  // framing pulse inside its window
    logic data;   // pulse inside the data window
    logic stray;  // pulse in neither window
    logic fin;    // framing window expired: burst over
  } rx_ev_t;
endpackage

// File: rtl/flp_tx.sv
module flp_tx
  import flp_pkg::*;
#(
  parameter int FRAME_GAP = 3125,
  parameter int DATA_OFS  = 1562,
  parameter int BURST_GAP = 400000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [NBITS-1:0] word_i,
  input  logic             valid_i,
  output logic             ready_o,
  output logic             pulse_o,
  output logic             busy_o
);
  localparam int CW = $clog2(FRAME_GAP);
  localparam int BW = $clog2(BURST_GAP);
  localparam int FW = $clog2(NFRAME + 1);
  localparam int IW = $clog2(NBITS);

  tx_state_e        st;
  logic [CW-1:0]    slot_cnt;
  logic [FW-1:0]    fidx;
  logic [BW-1:0]    per_cnt;
  logic [NBITS-1:0] cur_word;
  logic             have_word;
  logic             accept, data_slot, last_frame, slot_end, per_end;

  assign busy_o     = (st == TX_BURST);
  assign ready_o    = !busy_o;
  assign accept     = valid_i && ready_o;
  assign data_slot  = (fidx < FW'(NBITS)) && cur_word[fidx[IW-1:0]];
  assign pulse_o    = busy_o && ((slot_cnt == '0) ||
                      (slot_cnt == CW'(DATA_OFS) && data_slot));
  assign last_frame = (fidx == FW'(NFRAME - 1)) && (slot_cnt == '0);
  assign slot_end   = (slot_cnt == CW'(FRAME_GAP - 1));
  assign per_end    = (per_cnt == BW'(BURST_GAP - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= TX_IDLE;
      slot_cnt  <= '0;
      fidx      <= '0;
      per_cnt   <= '0;
      cur_word  <= '0;
      have_word <= 1'b0;
    end else begin
      if (accept) begin
        cur_word  <= word_i;
        have_word <= 1'b1;
      end
      unique case (st)
        TX_IDLE: begin
          if (run_i && have_word) begin
            st       <= TX_BURST;
            slot_cnt <= '0;
            fidx     <= '0;
            per_cnt  <= '0;
          end
        end
        TX_BURST: begin
          per_cnt <= per_cnt + 1'b1;
          if (last_frame) begin
            st <= TX_GAP;
          end else if (slot_end) begin
            slot_cnt <= '0;
            fidx     <= fidx + 1'b1;
          end else begin
            slot_cnt <= slot_cnt + 1'b1;
          end
        end
        TX_GAP: begin
          if (per_end) begin
            slot_cnt <= '0;
            fidx     <= '0;
            per_cnt  <= '0;
            st       <= (run_i && have_word) ? TX_BURST : TX_IDLE;
          end else begin
            per_cnt <= per_cnt + 1'b1;
          end
        end
        default: st <= TX_IDLE;
      endcase
    end
  end

  // R5: strobes never stretch over two cycles
  p_pulse_narrow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_o |=> !pulse_o);
  // R4: word under transmission is frozen for the whole burst
  p_word_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> (!busy_o || $stable(cur_word)));
  // R1: framing index never runs past the last framing pulse
  p_fidx_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (fidx < FW'(NFRAME)));
endmodule

// File: rtl/flp_rx_classify.sv
module flp_rx_classify
  import flp_pkg::*;
#(
  parameter int FRAME_GAP = 3125,
  parameter int DATA_OFS  = 1562,
  parameter int FRAME_TOL = 250,
  parameter int DATA_TOL  = 250
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   pulse_i,
  output rx_ev_t ev_o
);
  localparam int LIM = FRAME_GAP + FRAME_TOL;
  localparam int CW  = $clog2(LIM + 2);
  localparam logic [CW-1:0] D_LO = CW'(DATA_OFS - DATA_TOL);
  localparam logic [CW-1:0] D_HI = CW'(DATA_OFS + DATA_TOL);
  localparam logic [CW-1:0] F_LO = CW'(FRAME_GAP - FRAME_TOL);
  localparam logic [CW-1:0] F_HI = CW'(LIM);

  logic [CW-1:0] cnt;   // cycles since the last framing pulse
  logic          active;
  logic          in_data, in_frame;

  assign in_data  = (cnt >= D_LO) && (cnt <= D_HI);
  assign in_frame = (cnt >= F_LO) && (cnt <= F_HI);

  assign ev_o.start = pulse_i && !active;
  assign ev_o.frame = pulse_i && active && in_frame;
  assign ev_o.data  = pulse_i && active && in_data;
  assign ev_o.stray = pulse_i && active && !in_data && !in_frame;
  assign ev_o.fin   = active && !pulse_i && (cnt >= F_HI);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      active <= 1'b0;
    end else if (ev_o.start || ev_o.frame) begin
      cnt    <= CW'(1);
      active <= 1'b1;
    end else if (ev_o.fin) begin
      active <= 1'b0;
    end else if (active && cnt < F_HI) begin
      cnt <= cnt + 1'b1;
    end
  end

  // R8: a burst in progress always ends once the framing window lapses
  p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (cnt <= F_HI));
  // R6: each cycle is classified at most one way
  p_one_event_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ev_o));
  // R6: after the end of a burst the tracker is idle
  p_end_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_o.fin |=> !active);
endmodule

// File: rtl/flp_rx_assemble.sv
module flp_rx_assemble
  import flp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  rx_ev_t           ev_i,
  output logic [NBITS-1:0] word_o,
  output logic             ok_o,
  output logic             err_o
);
  localparam int FW = $clog2(NFRAME + 2);
  localparam int IW = $clog2(NBITS);

  logic [NBITS-1:0] acc;
  logic [FW-1:0]    fcnt;   // framing pulses seen, saturating
  logic [IW-1:0]    slot;
  logic             bad, seen;

  assign slot = IW'(fcnt - FW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc    <= '0;
      fcnt   <= '0;
      bad    <= 1'b0;
      seen   <= 1'b0;
      word_o <= '0;
      ok_o   <= 1'b0;
      err_o  <= 1'b0;
    end else begin
      ok_o  <= 1'b0;
      err_o <= 1'b0;
      if (ev_i.start) begin
        acc  <= '0;
        fcnt <= FW'(1);
        bad  <= 1'b0;
        seen <= 1'b0;
      end
      if (ev_i.frame) begin
        if (fcnt != FW'(NFRAME + 1)) fcnt <= fcnt + 1'b1;
        seen <= 1'b0;
      end
      if (ev_i.data) begin
        if (fcnt > FW'(NBITS) || seen) bad <= 1'b1;
        else acc[slot] <= 1'b1;
        seen <= 1'b1;
      end
      if (ev_i.stray) bad <= 1'b1;
      if (ev_i.fin) begin
        if (!bad && fcnt == FW'(NFRAME)) begin
          ok_o   <= 1'b1;
          word_o <= acc;
        end else begin
          err_o <= 1'b1;
        end
      end
    end
  end

  // R7: a burst resolves one way only
  p_ok_err_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(ok_o && err_o));
  // R7: an accepted burst had exactly 17 framing pulses
  p_ok_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ok_o |-> (fcnt == FW'(NFRAME)));
  // R8: no word comes out of a burst marked malformed
  p_ok_clean_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ok_o |-> !bad);
endmodule

// File: rtl/flp_out_slot.sv
module flp_out_slot #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_vld,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  output logic [W-1:0] out_data,
  input  logic         out_ready
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (!out_valid || out_ready) begin
      out_valid <= in_vld;
      if (in_vld) out_data <= in_data;
    end
  end

  // R9: a held word is neither lost nor altered under back-pressure
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

// File: rtl/flp_codec.sv
module flp_codec
  import flp_pkg::*;
#(
  parameter int FRAME_GAP = 3125,
  parameter int DATA_OFS  = 1562,
  parameter int BURST_GAP = 400000,
  parameter int FRAME_TOL = 250,
  parameter int DATA_TOL  = 250
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tx_run,
  input  logic [15:0] tx_word,
  input  logic        tx_valid,
  output logic        tx_ready,
  output logic        tx_pulse,
  output logic        tx_busy,
  input  logic        rx_pulse,
  output logic [15:0] rx_word,
  output logic        rx_valid,
  input  logic        rx_ready,
  output logic        rx_err
);
  rx_ev_t           ev;
  logic [NBITS-1:0] dec_word;
  logic             dec_ok;

  flp_tx #(.FRAME_GAP(FRAME_GAP), .DATA_OFS(DATA_OFS), .BURST_GAP(BURST_GAP)) u_tx (
    .clk(clk), .rst_n(rst_n), .run_i(tx_run), .word_i(tx_word), .valid_i(tx_valid),
    .ready_o(tx_ready), .pulse_o(tx_pulse), .busy_o(tx_busy));

  flp_rx_classify #(.FRAME_GAP(FRAME_GAP), .DATA_OFS(DATA_OFS),
                    .FRAME_TOL(FRAME_TOL), .DATA_TOL(DATA_TOL)) u_cls (
    .clk(clk), .rst_n(rst_n), .pulse_i(rx_pulse), .ev_o(ev));

  flp_rx_assemble u_asm (
    .clk(clk), .rst_n(rst_n), .ev_i(ev), .word_o(dec_word), .ok_o(dec_ok), .err_o(rx_err));

  flp_out_slot #(.W(NBITS)) u_slot (
    .clk(clk), .rst_n(rst_n), .in_vld(dec_ok), .in_data(dec_word),
    .out_valid(rx_valid), .out_data(rx_word), .out_ready(rx_ready));

  // R4: no word can be taken while a burst is on the line
  p_ready_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_busy |-> !tx_ready);
endmodule

// File: tb/flp_codec_tb_top.sv
`timescale 1ns/1ps
module flp_codec_tb_top;
  localparam int FG = 40, DO = 20, BG = 800, FT = 3, DT = 3;

  logic clk = 0, rst_n = 0;
  logic tx_run = 0, tx_valid = 0, rx_ready = 0, bench_rx = 0, loop = 0;
  logic [15:0] tx_word = '0;
  logic tx_ready, tx_pulse, tx_busy, rx_valid, rx_err, rx_line;
  logic [15:0] rx_word;

  int total = 0, bad = 0, cyc = 0, errs = 0;
  int ptimes[$];
  int bstart[$];
  logic busy_d = 0;
  bit done = 0;

  always #2.5 clk = ~clk;
  assign rx_line = loop ? tx_pulse : bench_rx;

  flp_codec #(.FRAME_GAP(FG), .DATA_OFS(DO), .BURST_GAP(BG),
              .FRAME_TOL(FT), .DATA_TOL(DT)) dut_i (
    .clk(clk), .rst_n(rst_n), .tx_run(tx_run), .tx_word(tx_word), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_pulse(tx_pulse), .tx_busy(tx_busy), .rx_pulse(rx_line),
    .rx_word(rx_word), .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_err(rx_err));

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (tx_pulse) ptimes.push_back(cyc);
    if (tx_busy && !busy_d) bstart.push_back(cyc);
    busy_d <= tx_busy;
    if (rx_err) errs <= errs + 1;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int popc(input logic [15:0] w);
    int n = 0;
    for (int i = 0; i < 16; i++) n += int'(w[i]);
    return n;
  endfunction

  function automatic int jit(input int t);
    return int'($urandom_range(2 * t)) - t;
  endfunction

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pw(input int n);
    bench_rx = 1;
    @(negedge clk);
    bench_rx = 0;
    waitn(n - 1);
  endtask

  task automatic load(input logic [15:0] w);
    while (!tx_ready) @(negedge clk);
    tx_word = w; tx_valid = 1;
    @(negedge clk);
    tx_valid = 0;
  endtask

  task automatic wait_burst_done();
    while (!tx_busy) @(negedge clk);
    chk(tx_ready == 0, "R4", "ready during burst", int'(tx_ready), 0);
    while (tx_busy) @(negedge clk);
  endtask

  // compare captured pulses with the expected positions of word w
  task automatic check_burst(input logic [15:0] w);
    int exp[$];
    int mism = -1;
    for (int k = 0; k < 17; k++) begin
      exp.push_back(k * FG);
      if (k < 16 && w[k]) exp.push_back(k * FG + DO);
    end
    chk(ptimes.size() == exp.size(), "R1", "pulse count", ptimes.size(), exp.size());
    if (ptimes.size() == exp.size()) begin
      for (int i = 0; i < exp.size(); i++)
        if (mism < 0 && ptimes[i] - ptimes[0] != exp[i]) mism = i;
      chk(mism < 0, "R2", "pulse offset", (mism < 0) ? 0 : ptimes[mism] - ptimes[0],
          (mism < 0) ? 0 : exp[mism]);
      for (int i = 1; i < ptimes.size(); i++)
        if (ptimes[i] - ptimes[i-1] < 2) chk(0, "R5", "pulse width", ptimes[i] - ptimes[i-1], 2);
    end
  endtask

  task automatic send(input logic [15:0] w, input int nfr, input int bad_k, input int bad_g,
                      input bit dup, input bit tail, input bit jt);
    for (int k = 0; k < nfr; k++) begin
      int g = FG + (jt ? jit(FT) : 0);
      int d = DO + (jt ? jit(DT) : 0);
      bit b = (k < 16) ? w[k] : 1'b0;
      if (k == bad_k) g = bad_g;
      if (k == nfr - 1) begin
        if (tail) begin pw(DO); pw(1); end
        else pw(1);
      end else if (b) begin
        pw(d);
        if (dup && k == 0) begin pw(1); pw(g - d - 1); end
        else pw(g - d);
      end else begin
        pw(g);
      end
    end
    waitn(FG + FT + 8);
  endtask

  task automatic pop();
    @(negedge clk) rx_ready = 1;
    @(negedge clk) rx_ready = 0;
  endtask

  task automatic expect_err(input string req, input string what, input int e0);
    chk(errs > e0, req, {what, " error strobe"}, errs - e0, 1);
    chk(rx_valid == 0, req, {what, " no word"}, int'(rx_valid), 0);
  endtask

  initial begin
    repeat (120000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired: got 0 expected 1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] w;
    int e0, n0;
    void'($urandom(32'd4242));
    waitn(3);
    rst_n = 1;
    waitn(2);
    // R10: reset state
    chk(tx_pulse == 0 && tx_busy == 0, "R10", "tx idle", int'({tx_pulse, tx_busy}), 0);
    chk(tx_ready == 1, "R10", "tx_ready", int'(tx_ready), 1);
    chk(rx_valid == 0 && rx_err == 0, "R10", "rx idle", int'({rx_valid, rx_err}), 0);

    // R1 R2 R4 R5: transmit patterns, repeated bursts
    for (int i = 0; i < 6; i++) begin
      w = (i == 0) ? 16'h0000 : (i == 1) ? 16'hFFFF : (i == 2) ? 16'h0001 : 16'($urandom);
      ptimes.delete();
      load(w);
      tx_run = 1;
      wait_burst_done();
      check_burst(w);
    end
    // R3: burst start spacing while running
    chk(bstart.size() >= 2 && bstart[bstart.size()-1] - bstart[bstart.size()-2] == BG,
        "R3", "burst period", bstart[bstart.size()-1] - bstart[bstart.size()-2], BG);

    // R3: stop mid-burst completes the burst and starts no more
    while (tx_busy) @(negedge clk);
    ptimes.delete();
    while (!tx_busy) @(negedge clk);
    tx_run = 0;
    while (tx_busy) @(negedge clk);
    n0 = ptimes.size();
    chk(n0 == 17 + popc(w), "R3", "burst finished after stop", n0, 17 + popc(w));
    waitn(2 * BG);
    chk(ptimes.size() == n0 && tx_busy == 0, "R3", "no burst after stop", ptimes.size(), n0);

    // R6: loop-back of one transmitted burst
    e0 = errs;
    loop = 1;
    load(16'hA5C3);
    tx_run = 1;
    while (!tx_busy) @(negedge clk);
    tx_run = 0;
    while (tx_busy) @(negedge clk);
    waitn(FG + FT + 8);
    chk(rx_valid == 1 && rx_word == 16'hA5C3, "R6", "loop-back word", int'(rx_word), 16'hA5C3);
    chk(errs == e0, "R6", "loop-back errors", errs - e0, 0);
    pop();
    loop = 0;

    // R6: random words with jitter inside both windows
    for (int i = 0; i < 12; i++) begin
      w = (i == 0) ? 16'hFFFF : (i == 1) ? 16'h0000 : 16'($urandom);
      e0 = errs;
      send(w, 17, -1, 0, 0, 0, 1);
      chk(rx_valid == 1 && rx_word == w, "R6", "decoded word", int'(rx_word), int'(w));
      chk(errs == e0, "R6", "no error", errs - e0, 0);
      pop();
      chk(rx_valid == 0, "R9", "valid clears on ready", int'(rx_valid), 0);
    end

    // R7: wrong framing counts
    e0 = errs; send(16'h1234, 16, -1, 0, 0, 0, 0); expect_err("R7", "16 frames", e0);
    e0 = errs; send(16'h1234, 18, -1, 0, 0, 0, 0); expect_err("R7", "18 frames", e0);
    // R8: short framing gap, doubled data pulse, trailing data pulse
    e0 = errs; send(16'h0F0F, 17, 5, FG - FT - 1, 0, 0, 0); expect_err("R8", "short gap", e0);
    e0 = errs; send(16'h0001, 17, -1, 0, 1, 0, 0); expect_err("R8", "double data", e0);
    e0 = errs; send(16'h8001, 17, -1, 0, 0, 1, 0); expect_err("R8", "trailing data", e0);
    // R6: edges of the tolerance windows still decode
    e0 = errs; send(16'h5555, 17, 3, FG + FT, 0, 0, 0);
    chk(rx_valid == 1 && rx_word == 16'h5555, "R6", "gap at upper edge", int'(rx_word), 16'h5555);
    pop();

    // R9: held word survives a second burst
    send(16'hBEEF, 17, -1, 0, 0, 0, 1);
    send(16'h1111, 17, -1, 0, 0, 0, 1);
    chk(rx_valid == 1 && rx_word == 16'hBEEF, "R9", "held word", int'(rx_word), 16'hBEEF);
    pop();
    chk(rx_valid == 0, "R9", "second word dropped", int'(rx_valid), 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule